// File: doc/BRIEF.md
# Bridging-Fault Emulating Lookahead Adder

This block is a 4-bit carry-lookahead adder that can imitate two kinds of short circuit on demand. It is meant for test-pattern experiments. A bench or a pattern generator applies operand pairs and a carry-in. It chooses a fault scenario through a two-bit select. It then watches whether the imitated defect becomes visible at the sum and carry outputs.

Two shorts are modelled.

- **Operand short:** a dominant-zero short joins the lowest operand bit of each input word. Both lines then take the AND of their healthy values before any generate or propagate term is formed.
- **Carry short:** a dominant-one short joins the carry into bit 1 and the carry into bit 2. Both lines then take the OR of their healthy values. Every later carry and sum is computed from those forced values.

The block also computes a healthy reference sum inside itself. A flag output goes high whenever the emulated faulty result differs from that reference. The block is purely combinational.

Top module: `fault_cla_adder`

## Requirements
- R1: With select 2'b00, {carryOut, sumOut} equals opA + opB + carryIn for every input.
- R2: With select 2'b01, bit 0 of both operands is replaced by opA[0] & opB[0]. {carryOut, sumOut} then equals the sum of the replaced operands plus carryIn.
- R3: With select 2'b01, sumOut[0] equals carryIn whatever the operand values.
- R4: With select 2'b10, the carries into bit 1 and bit 2 both take the OR of their healthy values. sumOut[1], sumOut[2], the carry into bit 3, sumOut[3] and carryOut are all formed from the forced values.
- R5: With select 2'b10, faultVisible is high exactly when the healthy carries into bit 1 and bit 2 differ. The case where the carry into bit 1 is 0 and the carry into bit 2 is 1 is one of these.
- R6: In every mode, faultVisible is high exactly when {carryOut, sumOut} differs from opA + opB + carryIn. It is therefore always low with select 2'b00 or 2'b11.
- R7: With select 2'b01, faultVisible is high exactly when opA[0] differs from opB[0].
- R8: Select 2'b11 behaves exactly like select 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 4 | First operand |
| opB | input | 4 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| faultSel | input | 2 | Fault scenario: 00 none, 01 operand AND-short, 10 carry OR-short, 11 none |
| sumOut | output | 4 | Sum bits, healthy or faulty per faultSel |
| carryOut | output | 1 | Carry out of bit 3 |
| faultVisible | output | 1 | High when the result differs from the healthy sum |

## Verification
The hardest situation to reach is an active carry short. It needs operands for which the healthy carries into bits 1 and 2 disagree. The opposite disagreement must also be exercised, where the carry into bit 1 is set but bit 1 neither generates nor propagates. The stimulus sweeps every operand pair, both carry-in values and all four select codes. This reaches every such combination deterministically.

The bench model derives each healthy carry from a partial integer sum. It then applies the OR forcing and re-adds the upper bits itself. The faulty sum and the visibility flag are therefore predicted without any lookahead structure.

// File: rtl/cla_fault_pkg.sv
`timescale 1ns/1ps
package cla_fault_pkg;
  typedef enum logic [1:0] {
    MODE_CLEAN    = 2'b00,
    MODE_OPER_AND = 2'b01,
    MODE_CARRY_OR = 2'b10,
    MODE_SPARE    = 2'b11
  } faultMode_e;

  typedef struct packed {
    logic bridgeOperands;
    logic bridgeCarries;
  } faultStrobes_t;
endpackage

// File: rtl/cla_fault_ctrl.sv
`timescale 1ns/1ps
module cla_fault_ctrl
  import cla_fault_pkg::*;
(
  input  logic [1:0]    faultSel,
  output faultStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    case (faultMode_e'(faultSel))
      MODE_OPER_AND: strobes.bridgeOperands = 1'b1;
      MODE_CARRY_OR: strobes.bridgeCarries  = 1'b1;
      default:       strobes = '0;  // clean and spare codes
    endcase
  end
endmodule

// File: rtl/cla_datapath.sv
`timescale 1ns/1ps
module cla_datapath
  import cla_fault_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter int OPER_BIT = 0,
  parameter int CARRY_LO = 1
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  faultStrobes_t    strobes,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut,
  output logic             faultVisible
);
  localparam int CARRY_HI = CARRY_LO + 1;

  // Carry into position hi from base carry entering position lo, in sum-of-products form
  function automatic logic lookahead(input logic [WIDTH-1:0] g,
                                     input logic [WIDTH-1:0] p,
                                     input logic base,
                                     input int lo, input int hi);
    logic acc;
    logic chain;
    chain = base;
    for (int j = lo; j < hi; j++) chain = chain & p[j];
    acc = chain;
    for (int j = lo; j < hi; j++) begin
      logic term;
      term = g[j];
      for (int k = j + 1; k < hi; k++) term = term & p[k];
      acc = acc | term;
    end
    return acc;
  endfunction

  logic [WIDTH-1:0] effA, effB, gen, prop, sumBits;
  logic [WIDTH:0]   carries, refTotal;
  logic             cleanLo, cleanHi, joined;

  always_comb begin
    effA = opA;
    effB = opB;
    if (strobes.bridgeOperands) begin
      effA[OPER_BIT] = opA[OPER_BIT] & opB[OPER_BIT];
      effB[OPER_BIT] = opA[OPER_BIT] & opB[OPER_BIT];
    end
    gen  = effA & effB;
    prop = effA ^ effB;
    carries[0] = carryIn;
    for (int k = 1; k <= WIDTH; k++) carries[k] = lookahead(gen, prop, carryIn, 0, k);
    cleanLo = carries[CARRY_LO];
    cleanHi = carries[CARRY_HI];
    joined  = cleanLo | cleanHi;
    if (strobes.bridgeCarries) begin
      carries[CARRY_LO] = joined;
      carries[CARRY_HI] = joined;
      for (int k = CARRY_HI + 1; k <= WIDTH; k++)
        carries[k] = lookahead(gen, prop, joined, CARRY_HI, k);
    end
    sumBits  = prop ^ carries[WIDTH-1:0];
    refTotal = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};
    faultVisible = ({carries[WIDTH], sumBits} != refTotal);

    // R3
    if (strobes.bridgeOperands) begin
      oper_bridge_sum_chk: assert (sumBits[OPER_BIT] == carries[OPER_BIT]);
    end
    // R7
    if (strobes.bridgeOperands) begin
      oper_bridge_vis_chk: assert (faultVisible == (opA[OPER_BIT] ^ opB[OPER_BIT]));
    end
    // R4
    if (strobes.bridgeCarries) begin
      carry_join_chk: assert (carries[CARRY_LO] == carries[CARRY_HI]);
    end
    // R5
    if (strobes.bridgeCarries) begin
      carry_expose_chk: assert (faultVisible == (cleanLo != cleanHi));
    end
    // R6
    if (!strobes.bridgeOperands && !strobes.bridgeCarries) begin
      clean_match_chk: assert (!faultVisible);
    end
  end

  assign sumOut   = sumBits;
  assign carryOut = carries[WIDTH];
endmodule

// File: rtl/fault_cla_adder.sv
`timescale 1ns/1ps
module fault_cla_adder
  import cla_fault_pkg::*;
(
  input  logic [3:0] opA,
  input  logic [3:0] opB,
  input  logic       carryIn,
  input  logic [1:0] faultSel,
  output logic [3:0] sumOut,
  output logic       carryOut,
  output logic       faultVisible
);
  faultStrobes_t strobes;

  cla_fault_ctrl i_ctrl (
    .faultSel (faultSel),
    .strobes  (strobes)
  );

  cla_datapath #(.WIDTH(4), .OPER_BIT(0), .CARRY_LO(1)) i_dp (
    .opA          (opA),
    .opB          (opB),
    .carryIn      (carryIn),
    .strobes      (strobes),
    .sumOut       (sumOut),
    .carryOut     (carryOut),
    .faultVisible (faultVisible)
  );
endmodule

// File: tb/test_fault_cla_adder.sv
`timescale 1ns/1ps
module test_fault_cla_adder;
  logic clk = 1'b0;
  logic [3:0] opA = '0, opB = '0;
  logic carryIn = 1'b0;
  logic [1:0] faultSel = 2'b00;
  logic [3:0] sumOut;
  logic carryOut, faultVisible;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fault_cla_adder i_fault_cla_adder (
    .opA(opA), .opB(opB), .carryIn(carryIn), .faultSel(faultSel),
    .sumOut(sumOut), .carryOut(carryOut), .faultVisible(faultVisible)
  );

  // Behavioural model: returns 5-bit faulty total; vis by comparison with healthy total
  function automatic int model(int a, int b, int c0, int sel);
    int total;
    total = a + b + c0;
    if (sel == 1) begin
      int bit0;
      bit0 = (a & 1) & (b & 1);
      total = (a & 14) + (b & 14) + 2 * bit0 + c0;
    end else if (sel == 2) begin
      int h1, h2, f, s1, s2, c3, s3, c4, s0;
      h1 = ((a & 1) + (b & 1) + c0) >> 1;
      h2 = ((a & 3) + (b & 3) + c0) >> 2;
      f  = h1 | h2;
      s0 = ((a & 1) + (b & 1) + c0) & 1;
      s1 = (((a >> 1) & 1) + ((b >> 1) & 1) + f) & 1;
      s2 = (((a >> 2) & 1) + ((b >> 2) & 1) + f) & 1;
      c3 = (((a >> 2) & 1) + ((b >> 2) & 1) + f) >> 1;
      s3 = (((a >> 3) & 1) + ((b >> 3) & 1) + c3) & 1;
      c4 = (((a >> 3) & 1) + ((b >> 3) & 1) + c3) >> 1;
      total = s0 + 2 * s1 + 4 * s2 + 8 * s3 + 16 * c4;
    end
    return total;
  endfunction

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (a=%0d b=%0d c=%0d sel=%0d)",
               tag, actual, expected, opA, opB, carryIn, faultSel);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // Idle state with all-zero inputs (R1)
    @(negedge clk);
    check("R1 idle", {faultVisible, carryOut, sumOut}, 0);
    for (int sel = 0; sel < 4; sel++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int c = 0; c < 2; c++) begin
            int exp, healthy, expVis;
            @(posedge clk);
            opA <= 4'(a); opB <= 4'(b); carryIn <= 1'(c); faultSel <= 2'(sel);
            @(negedge clk);
            exp = model(a, b, c, sel);
            healthy = a + b + c;
            expVis = (exp != healthy) ? 1 : 0;
            case (sel)
              0: check("R1 sum", {carryOut, sumOut}, exp);
              1: begin
                   check("R2 sum", {carryOut, sumOut}, exp);
                   check("R3 bit0", int'(sumOut[0]), c);
                   check("R7 vis", int'(faultVisible), ((a ^ b) & 1));
                 end
              2: begin
                   int h1, h2;
                   h1 = ((a & 1) + (b & 1) + c) >> 1;
                   h2 = ((a & 3) + (b & 3) + c) >> 2;
                   check("R4 sum", {carryOut, sumOut}, exp);
                   check("R5 vis", int'(faultVisible), (h1 != h2) ? 1 : 0);
                 end
              default: check("R8 sum", {carryOut, sumOut}, healthy);
            endcase
            check("R6 vis", int'(faultVisible), expVis);
          end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule